// File: doc/BRIEF.md
# Serial Packet Payload Decoder

This block sits behind a UART byte receiver. It turns the incoming byte stream into packet payloads. Payload bytes go downstream one at a time with a valid strobe, and the final byte of each payload carries a last flag. When a frame closes, a one-cycle status event reports the payload length and the outcome of an optional CRC check.

Four independent enables decide how a payload ends:
- a byte count, taken either from a four-byte packet header or from a configuration input;
- a 0xC0 delimiter byte, which applies when count termination is off;
- a line-idle report from the UART;
- a received break.

When CRC checking is on, two CRC bytes follow each payload and are compared against a CRC-16/CCITT computed over the payload bytes. A software-controlled reset holds the whole decoder idle for as long as it is asserted.

Top module: `pkt_payload_decoder`

## Requirements
- R1: After `rst_n` is released, `pl_valid`, `pl_last` and `st_valid` are 0. While `soft_rst` is 1, the decoder discards any partial frame and ignores incoming bytes. In the cycle after any cycle with `soft_rst` at 1, neither `pl_valid` nor `st_valid` is asserted.
- R2: With `cfg_len_end`=1 and `cfg_hdr_en`=0, the first byte seen while idle is payload byte 1. The payload closes on the byte whose running count reaches `cfg_len`, so the status length equals `cfg_len`.
- R3: With `cfg_len_end`=1 and `cfg_hdr_en`=1, each frame opens with four header bytes, numbered 0 to 3. Byte 2 is the low byte of the payload length and byte 3 is the high byte. Header bytes are never forwarded.
- R4: With `cfg_len_end`=0, a 0xC0 byte received while no payload is open starts a frame. A 0xC0 byte inside a payload closes it. Non-0xC0 bytes received while idle are dropped, and no 0xC0 byte is ever forwarded.
- R5: With `cfg_idle_end`=1, a pulse on `rx_idle` during a payload closes it. With `cfg_idle_end`=0, `rx_idle` has no effect.
- R6: With `cfg_brk_end`=1, a pulse on `rx_break` during a payload closes it. With `cfg_brk_end`=0, `rx_break` has no effect.
- R7: Payload bytes leave on `pl_data` in arrival order. `pl_last` is 1 only with the final byte of a payload.
- R8: With `cfg_crc_en`=1, the two bytes after the payload are the received CRC, most significant byte first. `st_crc_err` is 1 when that CRC differs from the CRC-16 over the payload bytes, computed with polynomial 0x1021, initial value 0xFFFF and no reflection. With `cfg_crc_en`=0, `st_crc_err` is 0.
- R9: A payload that closes with no bytes produces one status event with `st_len`=0 and forwards no data. Examples are a header length of zero and two back-to-back delimiters.
- R10: When several end conditions arrive in the same cycle, the frame closes once and produces exactly one status event.
- R11: Each frame produces one `st_valid` pulse whose `st_len` equals the number of payload bytes forwarded for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous decoder reset, held while 1 |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_idle | input | 1 | UART reports idle line (pulse) |
| rx_break | input | 1 | UART reports a break frame (pulse) |
| cfg_len_end | input | 1 | End payload by byte count (else by 0xC0) |
| cfg_hdr_en | input | 1 | Frames carry a four-byte header |
| cfg_idle_end | input | 1 | Idle line ends the payload |
| cfg_brk_end | input | 1 | Break ends the payload |
| cfg_crc_en | input | 1 | Two CRC bytes follow each payload |
| cfg_len | input | 16 | Target length when the header is off |
| pl_valid | output | 1 | Payload byte strobe |
| pl_data | output | 8 | Payload byte |
| pl_last | output | 1 | Final byte of the payload |
| st_valid | output | 1 | Frame status event |
| st_len | output | 16 | Payload length of the closed frame |
| st_crc_err | output | 1 | CRC mismatch on the closed frame |

## Verification
Some properties are checked on every cycle:
- `pl_last` never appears without `pl_valid`.
- A close always leaves the payload state.
- No 0xC0 byte is forwarded in delimiter mode.
- CRC errors are absent when checking is off.
- Outputs are quiet after a soft reset.
- Status length equals `cfg_len` in pure count mode.

Other behaviours can only be shown by the directed scenarios:
- correct byte order and placement of the last flag;
- header length capture;
- zero-length frames;
- a single close when idle, break and count coincide;
- CRC pass and fail against an independently computed CRC.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int LEN_W = 16;
  localparam logic [7:0] PD_DELIM = 8'hC0;
  localparam logic [15:0] PD_CRC_INIT = 16'hFFFF;
  localparam logic [15:0] PD_CRC_POLY = 16'h1021;

  typedef enum logic [1:0] {
    PD_IDLE = 2'd0,
    PD_HDR  = 2'd1,
    PD_PAY  = 2'd2,
    PD_CRC  = 2'd3
  } pd_state_t;

  // One byte through the CRC-16 shift register, MSB first
  function automatic logic [15:0] pd_crc_step(input logic [15:0] c_in, input logic [7:0] b);
    logic [15:0] c;
    c = c_in ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) begin
      c = c[15] ? ((c << 1) ^ PD_CRC_POLY) : (c << 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/pd_crc16.sv
module pd_crc16
  import pd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= PD_CRC_INIT;
    else if (clr) crc <= PD_CRC_INIT;
    else if (en)  crc <= pd_crc_step(crc, din);
  end
endmodule

// File: rtl/pd_hold.sv
module pd_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       push,
  input  logic [7:0] din,
  input  logic       mark_last,
  output logic       out_vld,
  output logic [7:0] out_dat,
  output logic       out_last
);
  logic       hold_vld;
  logic       hold_fin;
  logic [7:0] hold_dat;
  logic       emit;

  // a held byte leaves when a newer byte displaces it or when it is known final
  assign emit = hold_vld && (hold_fin || push);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld <= 1'b0;
      hold_fin <= 1'b0;
      hold_dat <= '0;
      out_vld  <= 1'b0;
      out_last <= 1'b0;
      out_dat  <= '0;
    end else if (clr) begin
      hold_vld <= 1'b0;
      hold_fin <= 1'b0;
      out_vld  <= 1'b0;
      out_last <= 1'b0;
    end else begin
      out_vld  <= emit;
      out_last <= emit && hold_fin;
      if (emit) out_dat <= hold_dat;
      if (push) begin
        hold_dat <= din;
        hold_vld <= 1'b1;
        hold_fin <= mark_last;
      end else if (hold_vld && hold_fin) begin
        hold_vld <= 1'b0;
        hold_fin <= 1'b0;
      end else if (mark_last && hold_vld) begin
        hold_fin <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pkt_payload_decoder.sv
module pkt_payload_decoder
  import pd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_idle,
  input  logic             rx_break,
  input  logic             cfg_len_end,
  input  logic             cfg_hdr_en,
  input  logic             cfg_idle_end,
  input  logic             cfg_brk_end,
  input  logic             cfg_crc_en,
  input  logic [LEN_W-1:0] cfg_len,
  output logic             pl_valid,
  output logic [7:0]       pl_data,
  output logic             pl_last,
  output logic             st_valid,
  output logic [LEN_W-1:0] st_len,
  output logic             st_crc_err
);
  pd_state_t        st;
  logic [1:0]       hdr_idx;
  logic [7:0]       hdr_lo;
  logic [LEN_W-1:0] hdr_len;
  logic [LEN_W-1:0] cnt;
  logic [7:0]       crc_hi;
  logic             crc_idx;
  logic [15:0]      crc_val;

  // named events, also seen by the checker
  logic             is_delim, start_pay, in_pay, pay_byte;
  logic             len_hit, delim_hit, idle_hit, brk_hit, zero_hit, close;
  logic             crc_last, frame_done;
  logic [LEN_W-1:0] cnt_nxt, target, close_len;
  pd_state_t        after_close;

  assign is_delim    = (rx_data == PD_DELIM);
  assign start_pay   = (st == PD_IDLE) && rx_valid && cfg_len_end && !cfg_hdr_en;
  assign in_pay      = (st == PD_PAY) && rx_valid && !(!cfg_len_end && is_delim);
  assign pay_byte    = start_pay || in_pay;
  assign cnt_nxt     = ((st == PD_IDLE) ? '0 : cnt) + 1'b1;
  assign target      = cfg_hdr_en ? hdr_len : cfg_len;
  assign len_hit     = pay_byte && cfg_len_end && (cnt_nxt >= target);
  assign delim_hit   = (st == PD_PAY) && rx_valid && !cfg_len_end && is_delim;
  assign idle_hit    = (st == PD_PAY) && cfg_idle_end && rx_idle;
  assign brk_hit     = (st == PD_PAY) && cfg_brk_end && rx_break;
  assign zero_hit    = (st == PD_HDR) && rx_valid && (hdr_idx == 2'd3) && cfg_len_end
                       && ({rx_data, hdr_lo} == '0);
  assign close       = len_hit || delim_hit || idle_hit || brk_hit || zero_hit;
  assign close_len   = pay_byte ? cnt_nxt : cnt;
  assign crc_last    = (st == PD_CRC) && rx_valid && crc_idx;
  assign frame_done  = (close && !cfg_crc_en) || crc_last;
  assign after_close = cfg_crc_en ? PD_CRC : PD_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= PD_IDLE; hdr_idx <= '0; hdr_lo <= '0; hdr_len <= '0; cnt <= '0;
      crc_hi <= '0; crc_idx <= 1'b0;
      st_valid <= 1'b0; st_len <= '0; st_crc_err <= 1'b0;
    end else if (soft_rst) begin
      st <= PD_IDLE; hdr_idx <= '0; cnt <= '0; crc_idx <= 1'b0;
      st_valid <= 1'b0; st_crc_err <= 1'b0;
    end else begin
      if (pay_byte)            cnt <= cnt_nxt;
      else if (st == PD_IDLE)  cnt <= '0;
      case (st)
        PD_IDLE: if (rx_valid) begin
          if (cfg_len_end) begin
            if (cfg_hdr_en) begin st <= PD_HDR; hdr_idx <= 2'd1; end
            else            st <= close ? after_close : PD_PAY;
          end else if (is_delim) begin
            st <= cfg_hdr_en ? PD_HDR : PD_PAY;
            hdr_idx <= 2'd0;
          end
        end
        PD_HDR: if (rx_valid) begin
          hdr_idx <= hdr_idx + 1'b1;
          if (hdr_idx == 2'd2) hdr_lo <= rx_data;
          if (hdr_idx == 2'd3) begin
            hdr_len <= {rx_data, hdr_lo};
            st      <= zero_hit ? after_close : PD_PAY;
          end
        end
        PD_PAY: if (close) st <= after_close;
        PD_CRC: if (rx_valid) begin
          if (!crc_idx) begin crc_hi <= rx_data; crc_idx <= 1'b1; end
          else          begin st <= PD_IDLE; crc_idx <= 1'b0; end
        end
        default: st <= PD_IDLE;
      endcase
      st_valid <= frame_done;
      if (close && !cfg_crc_en) begin
        st_len     <= close_len;
        st_crc_err <= 1'b0;
      end else if (crc_last) begin
        st_len     <= cnt;
        st_crc_err <= ({crc_hi, rx_data} != crc_val);
      end
    end
  end

  pd_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst || frame_done),
    .en(pay_byte), .din(rx_data), .crc(crc_val)
  );

  pd_hold u_hold (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst),
    .push(pay_byte), .din(rx_data), .mark_last(close),
    .out_vld(pl_valid), .out_dat(pl_data), .out_last(pl_last)
  );
endmodule

// File: rtl/pd_checker.sv
module pd_checker
  import pd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             cfg_len_end,
  input logic             cfg_hdr_en,
  input logic             cfg_idle_end,
  input logic             cfg_brk_end,
  input logic             cfg_crc_en,
  input logic [LEN_W-1:0] cfg_len,
  input logic             pl_valid,
  input logic [7:0]       pl_data,
  input logic             pl_last,
  input logic             st_valid,
  input logic [LEN_W-1:0] st_len,
  input logic             st_crc_err,
  input logic             close,
  input pd_state_t        st
);
  // R7
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pl_last |-> pl_valid);

  // R10
  close_leaves_pay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> (st != PD_PAY));

  // R4
  no_delim_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && !cfg_len_end) |-> (pl_data != PD_DELIM));

  // R8
  crc_off_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !cfg_crc_en) |-> !st_crc_err);

  // R1
  soft_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!pl_valid && !st_valid));

  // R2
  cfg_len_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && cfg_len_end && !cfg_hdr_en && !cfg_idle_end && !cfg_brk_end && (cfg_len != '0))
      |-> (st_len == cfg_len));
endmodule

bind pkt_payload_decoder pd_checker u_pd_checker (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
  .cfg_len_end(cfg_len_end), .cfg_hdr_en(cfg_hdr_en), .cfg_idle_end(cfg_idle_end),
  .cfg_brk_end(cfg_brk_end), .cfg_crc_en(cfg_crc_en), .cfg_len(cfg_len),
  .pl_valid(pl_valid), .pl_data(pl_data), .pl_last(pl_last),
  .st_valid(st_valid), .st_len(st_len), .st_crc_err(st_crc_err),
  .close(close), .st(st)
);

// File: tb/pkt_payload_decoder_bench.sv
module pkt_payload_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_idle = 1'b0, rx_break = 1'b0;
  logic cfg_len_end = 1'b0, cfg_hdr_en = 1'b0, cfg_idle_end = 1'b0;
  logic cfg_brk_end = 1'b0, cfg_crc_en = 1'b0;
  logic [15:0] cfg_len = 16'd1;
  logic pl_valid, pl_last, st_valid, st_crc_err;
  logic [7:0] pl_data;
  logic [15:0] st_len;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0]  got_d[$];
  logic        got_l[$];
  logic [15:0] got_len[$];
  logic        got_err[$];
  logic [7:0]  exp_d[$];
  logic        exp_l[$];
  logic [15:0] exp_len[$];
  logic        exp_err[$];

  always #4 clk = ~clk;

  pkt_payload_decoder u_pkt_payload_decoder (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_idle(rx_idle), .rx_break(rx_break),
    .cfg_len_end(cfg_len_end), .cfg_hdr_en(cfg_hdr_en), .cfg_idle_end(cfg_idle_end),
    .cfg_brk_end(cfg_brk_end), .cfg_crc_en(cfg_crc_en), .cfg_len(cfg_len),
    .pl_valid(pl_valid), .pl_data(pl_data), .pl_last(pl_last),
    .st_valid(st_valid), .st_len(st_len), .st_crc_err(st_crc_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (pl_valid) begin got_d.push_back(pl_data); got_l.push_back(pl_last); end
      if (st_valid) begin got_len.push_back(st_len); got_err.push_back(st_crc_err); end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] x;
    x = {8'h00, c[15:8] ^ b};
    x = x ^ (x >> 4);
    x = x & 16'h00FF;
    return (c << 8) ^ (x << 12) ^ (x << 5) ^ x;
  endfunction

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send_with_idle(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b; rx_idle = 1'b1;
    @(negedge clk); rx_valid = 1'b0; rx_idle = 1'b0;
  endtask

  task automatic pulse(input bit idl, input bit brk);
    @(negedge clk); rx_idle = idl; rx_break = brk;
    @(negedge clk); rx_idle = 1'b0; rx_break = 1'b0;
  endtask

  task automatic want_byte(input logic [7:0] b, input bit last);
    exp_d.push_back(b); exp_l.push_back(last);
  endtask

  task automatic want_stat(input logic [15:0] len, input bit err);
    exp_len.push_back(len); exp_err.push_back(err);
  endtask

  task automatic compare(input string req);
    repeat (6) @(negedge clk);
    chk(got_d.size() == exp_d.size(), {req, " byte count"}, got_d.size(), exp_d.size());
    chk(got_len.size() == exp_len.size(), {req, " status count"}, got_len.size(), exp_len.size());
    for (int i = 0; i < exp_d.size() && i < got_d.size(); i++) begin
      chk(got_d[i] == exp_d[i], {req, " data"}, got_d[i], exp_d[i]);
      chk(got_l[i] == exp_l[i], {req, " R7 last"}, got_l[i], exp_l[i]);
    end
    for (int i = 0; i < exp_len.size() && i < got_len.size(); i++) begin
      chk(got_len[i] == exp_len[i], {req, " R11 len"}, got_len[i], exp_len[i]);
      chk(got_err[i] == exp_err[i], {req, " crc err"}, got_err[i], exp_err[i]);
    end
    got_d.delete(); got_l.delete(); got_len.delete(); got_err.delete();
    exp_d.delete(); exp_l.delete(); exp_len.delete(); exp_err.delete();
  endtask

  task automatic set_mode(input bit le, input bit he, input bit ie, input bit be, input bit ce,
                          input logic [15:0] l);
    @(negedge clk);
    cfg_len_end = le; cfg_hdr_en = he; cfg_idle_end = ie; cfg_brk_end = be;
    cfg_crc_en = ce; cfg_len = l;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pl_valid && !pl_last && !st_valid, "R1 reset outputs", {pl_valid, pl_last, st_valid}, 0);
  endtask

  task automatic t_cfg_len();
    set_mode(1, 0, 0, 0, 0, 16'd3);
    send(8'hA1); send(8'hA2); send(8'hA3);
    want_byte(8'hA1, 0); want_byte(8'hA2, 0); want_byte(8'hA3, 1); want_stat(3, 0);
    send(8'hB1); send(8'hC0); send(8'hB3);
    want_byte(8'hB1, 0); want_byte(8'hC0, 0); want_byte(8'hB3, 1); want_stat(3, 0);
    compare("R2");
  endtask

  task automatic t_header();
    set_mode(1, 1, 0, 0, 0, 16'd9);
    send(8'h11); send(8'h22); send(8'h02); send(8'h00);
    send(8'h55); send(8'h66);
    want_byte(8'h55, 0); want_byte(8'h66, 1); want_stat(2, 0);
    compare("R3");
  endtask

  task automatic t_header_zero();
    set_mode(1, 1, 0, 0, 0, 16'd9);
    send(8'h11); send(8'h22); send(8'h00); send(8'h00);
    want_stat(0, 0);
    compare("R9 header zero");
  endtask

  task automatic t_delim();
    set_mode(0, 0, 0, 0, 0, 16'd1);
    send(8'h44); send(8'hC0); send(8'h31); send(8'h32); send(8'hC0);
    want_byte(8'h31, 0); want_byte(8'h32, 1); want_stat(2, 0);
    send(8'hC0); send(8'hC0);
    want_stat(0, 0);
    compare("R4 R9 delimiter");
  endtask

  task automatic t_idle();
    set_mode(0, 0, 1, 0, 0, 16'd1);
    send(8'hC0); send(8'h41); send(8'h42); pulse(1, 0);
    want_byte(8'h41, 0); want_byte(8'h42, 1); want_stat(2, 0);
    compare("R5 idle end");
  endtask

  task automatic t_break();
    set_mode(0, 0, 0, 1, 0, 16'd1);
    send(8'hC0); send(8'h61); pulse(1, 0); send(8'h62);
    repeat (3) @(negedge clk);
    chk(got_len.size() == 0, "R5 idle ignored when off", got_len.size(), 0);
    pulse(0, 1);
    want_byte(8'h61, 0); want_byte(8'h62, 1); want_stat(2, 0);
    compare("R6 break end");
  endtask

  task automatic t_crc();
    logic [15:0] c;
    set_mode(1, 0, 0, 0, 1, 16'd2);
    c = ref_step(ref_step(16'hFFFF, 8'h12), 8'h34);
    send(8'h12); send(8'h34); send(c[15:8]); send(c[7:0]);
    want_byte(8'h12, 0); want_byte(8'h34, 1); want_stat(2, 0);
    c = ref_step(ref_step(16'hFFFF, 8'h56), 8'h78) ^ 16'h0100;
    send(8'h56); send(8'h78); send(c[15:8]); send(c[7:0]);
    want_byte(8'h56, 0); want_byte(8'h78, 1); want_stat(2, 1);
    compare("R8 crc");
  endtask

  task automatic t_coincide();
    set_mode(0, 0, 1, 1, 0, 16'd1);
    send(8'hC0); send(8'h51); pulse(1, 1);
    want_byte(8'h51, 1); want_stat(1, 0);
    compare("R10 idle+break");
    set_mode(1, 0, 1, 0, 0, 16'd2);
    send(8'h71); send_with_idle(8'h72);
    want_byte(8'h71, 0); want_byte(8'h72, 1); want_stat(2, 0);
    compare("R10 count+idle");
  endtask

  task automatic t_soft();
    set_mode(1, 0, 0, 0, 0, 16'd3);
    send(8'h99);
    @(negedge clk); soft_rst = 1'b1; rx_valid = 1'b1; rx_data = 8'h98;
    @(negedge clk); rx_valid = 1'b0;
    chk(!pl_valid && !st_valid, "R1 soft reset quiet", {pl_valid, st_valid}, 0);
    @(negedge clk); soft_rst = 1'b0;
    send(8'h81); send(8'h82); send(8'h83);
    want_byte(8'h81, 0); want_byte(8'h82, 0); want_byte(8'h83, 1); want_stat(3, 0);
    compare("R1 soft reset");
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_cfg_len();
    t_header();
    t_header_zero();
    t_delim();
    t_idle();
    t_break();
    t_crc();
    t_coincide();
    t_soft();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule